// File: doc/BRIEF.md
# Vertex attribute offset generator

This block lays out the attributes of one interleaved vertex record and turns a stream of vertex indices into per-attribute byte addresses. Configuration supplies a list of attribute descriptors, one type code and one component count each. It also supplies the number of active descriptors, a programmed record stride and a buffer base address. The block places each attribute directly after the end of the one before it, in list order. Each start is rounded up to the alignment that the attribute's type demands. The resulting offset of every slot is presented as a parallel output bus.

The programmed stride is the plain sum of the laid-out attributes, with no rounding of the record end. When the stride does not equal that end, the block raises a configuration error and refuses new vertex requests. Once the configuration is consistent, each accepted vertex index produces one address per active attribute over a valid/ready handshake, and the final one is marked as last. The configuration is expected to stay stable while a vertex is being emitted.

Top module: `vtx_attr_addr_gen`

## Requirements
- R1: Type codes 0 to 3 have a 1-byte element, codes 4 to 7 a 2-byte element, and codes 8 to 11 a 4-byte element. A count field value c means c+1 components, so a real attribute occupies element size times (c+1) bytes.
- R2: Attribute 0 starts at offset 0. Every later attribute starts at the end of the previous attribute, rounded up to a multiple of its own alignment. For a real attribute that alignment is its element size. `attr_offset` carries the start of slot k in bits [k*8 +: 8].
- R3: Type codes 12 to 15 are padding. A padding attribute occupies 4*(c+1) bytes and always starts at a multiple of 4, whatever the previous attribute's size.
- R4: `cfg_err` is high exactly when `cfg_num_attr` lies outside 1..12, or when `cfg_stride` differs from the unrounded end of the last active attribute.
- R5: While `cfg_err` is high, `vtx_ready` stays low and no vertex request is accepted.
- R6: An accepted vertex index n produces one output beat per active attribute, with `out_attr` running 0, 1, ... in order. Each address equals base + n*stride + offset of that attribute, and `out_last` is set on the beat for attribute `cfg_num_attr`-1 only.
- R7: While `out_valid` is high and `out_ready` is low, `out_addr`, `out_attr` and `out_last` hold their values.
- R8: `vtx_ready` is low while a vertex is being emitted. It is high again in the cycle after the last beat is taken, provided the configuration is consistent.
- R9: After reset `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_num_attr | input | 4 | Number of active descriptors (1..12) |
| cfg_type | input | 48 | Type code of slot k in bits [k*4 +: 4] |
| cfg_cnt | input | 24 | Component count minus one of slot k in bits [k*2 +: 2] |
| cfg_stride | input | 8 | Programmed record stride in bytes, unrounded |
| cfg_base | input | 32 | Buffer base byte address |
| attr_offset | output | 96 | Start offset of slot k in bits [k*8 +: 8] |
| cfg_err | output | 1 | Stride or count configuration error |
| vtx_valid | input | 1 | Vertex index request valid |
| vtx_ready | output | 1 | Block can take a vertex index |
| vtx_index | input | 16 | Vertex index |
| out_valid | output | 1 | Attribute address valid |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | 32 | Attribute byte address |
| out_attr | output | 4 | Attribute slot of the current address |
| out_last | output | 1 | Current address is the record's final attribute |

## Verification
The configuration check and vertex acceptance meet in one cycle when a request is held valid while the stride disagrees with the layout. The bench presents vertex requests against strides one byte too large, and against strides rounded up to the next multiple of 4. It then judges that `vtx_ready` stays low and no beat appears. Emission and back-pressure also coincide: `out_ready` is dropped on the beat that follows acceptance, and the held address and slot number are compared cycle by cycle against the reference layout.

// File: rtl/vag_pkg.sv
package vag_pkg;

   localparam int TYPE_W       = 4;
   localparam int CNT_W        = 2;
   localparam int PAD_CODE_MIN = 12;

   function automatic logic is_padding(logic [TYPE_W-1:0] t);
      return (int'(t) >= PAD_CODE_MIN);
   endfunction

   function automatic logic [2:0] elem_bytes(logic [TYPE_W-1:0] t);
      if (t < 4'd4)      return 3'd1;
      else if (t < 4'd8) return 3'd2;
      else               return 3'd4;
   endfunction

   function automatic logic [2:0] attr_align(logic [TYPE_W-1:0] t);
      return is_padding(t) ? 3'd4 : elem_bytes(t);
   endfunction

   function automatic logic [4:0] attr_bytes(logic [TYPE_W-1:0] t, logic [CNT_W-1:0] c);
      logic [4:0] n;
      n = 5'(c) + 5'd1;
      return is_padding(t) ? (n << 2) : (5'(elem_bytes(t)) * n);
   endfunction

endpackage

// File: rtl/vag_layout_cell.sv
module vag_layout_cell
   import vag_pkg::*;
#(
   parameter int OFF_W = 8
) (
   input  logic [OFF_W-1:0]  prev_end,
   input  logic [TYPE_W-1:0] a_type,
   input  logic [CNT_W-1:0]  a_cnt,
   output logic [OFF_W-1:0]  a_offset,
   output logic [OFF_W-1:0]  a_end
);

   logic [OFF_W-1:0] align_m1;

   always_comb begin
      align_m1 = OFF_W'(attr_align(a_type)) - OFF_W'(1);
      a_offset = (prev_end + align_m1) & ~align_m1;
      a_end    = a_offset + OFF_W'(attr_bytes(a_type, a_cnt));
   end

endmodule

// File: rtl/vag_cfg_check.sv
module vag_cfg_check #(
   parameter int MAX_ATTR = 12,
   parameter int NUM_W    = 4,
   parameter int OFF_W    = 8
) (
   input  logic [MAX_ATTR*OFF_W-1:0] ends_flat,
   input  logic [NUM_W-1:0]          num_attr,
   input  logic [OFF_W-1:0]          stride,
   output logic                      cfg_err
);

   logic [OFF_W-1:0] rec_size;
   logic             num_ok;

   always_comb begin
      rec_size = '0;
      num_ok   = 1'b0;
      for (int i = 0; i < MAX_ATTR; i++) begin
         if (int'(num_attr) == i + 1) begin
            rec_size = ends_flat[i*OFF_W +: OFF_W];
            num_ok   = 1'b1;
         end
      end
      cfg_err = !num_ok || (rec_size != stride);
   end

endmodule

// File: rtl/vag_addr_seq.sv
module vag_addr_seq #(
   parameter int MAX_ATTR = 12,
   parameter int NUM_W    = 4,
   parameter int OFF_W    = 8,
   parameter int ADDR_W   = 32,
   parameter int IDX_W    = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_err,
   input  logic [NUM_W-1:0]          num_attr,
   input  logic [OFF_W-1:0]          stride,
   input  logic [ADDR_W-1:0]         base,
   input  logic [MAX_ATTR*OFF_W-1:0] offsets,
   input  logic                      vtx_valid,
   output logic                      vtx_ready,
   input  logic [IDX_W-1:0]          vtx_index,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [ADDR_W-1:0]         out_addr,
   output logic [NUM_W-1:0]          out_attr,
   output logic                      out_last
);

   typedef enum logic {S_IDLE, S_EMIT} seq_state_t;

   seq_state_t       state;
   logic [NUM_W-1:0] slot;
   logic [ADDR_W-1:0] rec_base;
   logic [OFF_W-1:0] cur_off;

   assign vtx_ready = (state == S_IDLE) && !cfg_err;
   assign out_valid = (state == S_EMIT);
   assign out_attr  = slot;
   assign out_last  = (int'(slot) == int'(num_attr) - 1);
   assign out_addr  = rec_base + ADDR_W'(cur_off);

   always_comb begin
      cur_off = '0;
      for (int i = 0; i < MAX_ATTR; i++)
         if (int'(slot) == i) cur_off = offsets[i*OFF_W +: OFF_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         slot     <= '0;
         rec_base <= '0;
      end else begin
         case (state)
            S_IDLE: if (vtx_valid && vtx_ready) begin
               state    <= S_EMIT;
               slot     <= '0;
               rec_base <= base + ADDR_W'(vtx_index) * ADDR_W'(stride);
            end
            S_EMIT: if (out_ready) begin
               if (out_last) state <= S_IDLE;
               else          slot  <= slot + NUM_W'(1);
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !out_valid) |=> !out_valid); // R5
   AST_FIRST_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
      (vtx_valid && vtx_ready) |=> (out_valid && out_attr == '0)); // R6
   AST_ATTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_last) |=> (out_valid && out_attr == $past(out_attr) + NUM_W'(1))); // R6
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_attr) && $stable(out_last))); // R7
   AST_RETURN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> !out_valid); // R8
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !vtx_ready); // R8

endmodule

// File: rtl/vtx_attr_addr_gen.sv
module vtx_attr_addr_gen
   import vag_pkg::*;
#(
   parameter int MAX_ATTR = 12,
   parameter int OFF_W    = 8,
   parameter int ADDR_W   = 32,
   parameter int IDX_W    = 16,
   localparam int NUM_W   = $clog2(MAX_ATTR + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_W-1:0]           cfg_num_attr,
   input  logic [MAX_ATTR*TYPE_W-1:0] cfg_type,
   input  logic [MAX_ATTR*CNT_W-1:0]  cfg_cnt,
   input  logic [OFF_W-1:0]           cfg_stride,
   input  logic [ADDR_W-1:0]          cfg_base,
   output logic [MAX_ATTR*OFF_W-1:0]  attr_offset,
   output logic                       cfg_err,
   input  logic                       vtx_valid,
   output logic                       vtx_ready,
   input  logic [IDX_W-1:0]           vtx_index,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic [ADDR_W-1:0]          out_addr,
   output logic [NUM_W-1:0]           out_attr,
   output logic                       out_last
);

   localparam int WORST_REC = MAX_ATTR * 20;

   if (MAX_ATTR < 1 || MAX_ATTR > 15) begin : g_bad_max_attr
      $error("MAX_ATTR must lie in 1..15");
   end
   if (WORST_REC >= (1 << OFF_W)) begin : g_bad_off_w
      $error("OFF_W too narrow for the worst-case record");
   end
   if (ADDR_W < OFF_W || ADDR_W < IDX_W) begin : g_bad_addr_w
      $error("ADDR_W must cover OFF_W and IDX_W");
   end

   logic [MAX_ATTR*OFF_W-1:0] ends_flat;

   for (genvar g = 0; g < MAX_ATTR; g++) begin : g_cell
      logic [OFF_W-1:0] prev_end;
      if (g == 0) begin : g_head
         assign prev_end = '0;
      end else begin : g_link
         assign prev_end = ends_flat[(g-1)*OFF_W +: OFF_W];
      end
      vag_layout_cell #(.OFF_W(OFF_W)) u_cell (
         .prev_end (prev_end),
         .a_type   (cfg_type[g*TYPE_W +: TYPE_W]),
         .a_cnt    (cfg_cnt[g*CNT_W +: CNT_W]),
         .a_offset (attr_offset[g*OFF_W +: OFF_W]),
         .a_end    (ends_flat[g*OFF_W +: OFF_W])
      );
   end

   vag_cfg_check #(.MAX_ATTR(MAX_ATTR), .NUM_W(NUM_W), .OFF_W(OFF_W)) u_check (
      .ends_flat (ends_flat),
      .num_attr  (cfg_num_attr),
      .stride    (cfg_stride),
      .cfg_err   (cfg_err)
   );

   vag_addr_seq #(
      .MAX_ATTR(MAX_ATTR), .NUM_W(NUM_W), .OFF_W(OFF_W),
      .ADDR_W(ADDR_W), .IDX_W(IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_err   (cfg_err),
      .num_attr  (cfg_num_attr),
      .stride    (cfg_stride),
      .base      (cfg_base),
      .offsets   (attr_offset),
      .vtx_valid (vtx_valid),
      .vtx_ready (vtx_ready),
      .vtx_index (vtx_index),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_addr  (out_addr),
      .out_attr  (out_attr),
      .out_last  (out_last)
   );

endmodule

// File: tb/vtx_attr_addr_gen_bench.sv
`timescale 1ns/1ps
module vtx_attr_addr_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  cfg_num_attr;
   logic [47:0] cfg_type;
   logic [23:0] cfg_cnt;
   logic [7:0]  cfg_stride;
   logic [31:0] cfg_base;
   logic [95:0] attr_offset;
   logic        cfg_err;
   logic        vtx_valid;
   logic        vtx_ready;
   logic [15:0] vtx_index;
   logic        out_valid;
   logic        out_ready;
   logic [31:0] out_addr;
   logic [3:0]  out_attr;
   logic        out_last;

   int n_cmp  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   vtx_attr_addr_gen u_vtx_attr_addr_gen (
      .clk(clk), .rst_n(rst_n), .cfg_num_attr(cfg_num_attr), .cfg_type(cfg_type),
      .cfg_cnt(cfg_cnt), .cfg_stride(cfg_stride), .cfg_base(cfg_base),
      .attr_offset(attr_offset), .cfg_err(cfg_err), .vtx_valid(vtx_valid),
      .vtx_ready(vtx_ready), .vtx_index(vtx_index), .out_valid(out_valid),
      .out_ready(out_ready), .out_addr(out_addr), .out_attr(out_attr), .out_last(out_last)
   );

   // {num[83:80], types[79:32], counts[31:8], expected record size[7:0]}
   localparam logic [83:0] VEC [6] = '{
      {4'd3,  48'h000000000048, 24'h00003B, 8'd26},
      {4'd4,  48'h0000000040C0, 24'h000020, 8'd14},
      {4'd4,  48'h0000000018D4, 24'h000004, 8'd17},
      {4'd1,  48'h000000000008, 24'h000003, 8'd16},
      {4'd12, 48'h000000000000, 24'h000000, 8'd12},
      {4'd2,  48'h000000000080, 24'h000002, 8'd8}
   };

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Independent layout model: offset of slot k and end of slot k.
   task automatic ref_layout(input int k, input logic [47:0] t, input logic [23:0] c,
                             output int off, output int fin);
      int pos = 0;
      off = 0;
      for (int i = 0; i <= k; i++) begin
         int ty = int'(t[i*4 +: 4]);
         int n  = int'(c[i*2 +: 2]) + 1;
         int al, sz;
         if (ty >= 12) begin al = 4; sz = 4 * n; end
         else begin al = (ty < 4) ? 1 : (ty < 8) ? 2 : 4; sz = al * n; end
         pos = ((pos + al - 1) / al) * al;
         off = pos;
         pos = pos + sz;
      end
      fin = pos;
   endtask

   task automatic run_vertex(input int idx, input int num, input string tag);
      logic [31:0] exp;
      int off, fin;
      @(negedge clk);
      vtx_index = 16'(idx);
      vtx_valid = 1'b1;
      chk(vtx_ready == 1'b1, "R8", vtx_ready, 1);
      @(posedge clk);
      @(negedge clk);
      vtx_valid = 1'b0;
      for (int k = 0; k < num; k++) begin
         ref_layout(k, cfg_type, cfg_cnt, off, fin);
         exp = cfg_base + 32'(idx) * 32'(cfg_stride) + 32'(off);
         chk(out_valid && out_attr == 4'(k), {tag, " R6 slot"}, out_attr, k);
         chk(out_addr == exp, {tag, " R6 addr"}, out_addr, exp);
         chk(out_last == (k == num - 1), {tag, " R6 last"}, out_last, (k == num - 1));
         chk(vtx_ready == 1'b0, "R8 busy", vtx_ready, 0);
         @(posedge clk);
         @(negedge clk);
      end
      chk(!out_valid && vtx_ready, "R8 idle", {out_valid, vtx_ready}, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

   initial begin
      int off, fin;
      rst_n = 1'b0; vtx_valid = 1'b0; vtx_index = '0; out_ready = 1'b1;
      cfg_num_attr = VEC[0][83:80]; cfg_type = VEC[0][79:32];
      cfg_cnt = VEC[0][31:8]; cfg_stride = VEC[0][7:0]; cfg_base = 32'h1000_0000;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0 && vtx_ready, "R9 after reset", {out_valid, vtx_ready}, 1);

      // Table walk: layout, stride check, address stream.
      for (int v = 0; v < 6; v++) begin
         @(negedge clk);
         cfg_num_attr = VEC[v][83:80]; cfg_type = VEC[v][79:32];
         cfg_cnt = VEC[v][31:8]; cfg_stride = VEC[v][7:0];
         #1;
         for (int k = 0; k < int'(cfg_num_attr); k++) begin
            ref_layout(k, cfg_type, cfg_cnt, off, fin);
            chk(attr_offset[k*8 +: 8] == 8'(off),
                (cfg_type[k*4 +: 4] >= 4'd12) ? "R3 pad offset" : "R2 offset",
                attr_offset[k*8 +: 8], off);
         end
         ref_layout(int'(cfg_num_attr) - 1, cfg_type, cfg_cnt, off, fin);
         chk(fin == int'(VEC[v][7:0]), "R1 record size", fin, VEC[v][7:0]);
         chk(cfg_err == 1'b0, "R4 matching stride", cfg_err, 0);
         run_vertex(v * 7 + 1, int'(cfg_num_attr), "table");
      end

      // Directed: hand-derived offsets with padding before odd-sized attributes.
      @(negedge clk);
      cfg_num_attr = 4'd4; cfg_type = 48'h40C0; cfg_cnt = 24'h20; cfg_stride = 8'd14;
      #1;
      chk(attr_offset[15:8] == 8'd4, "R3 pad after 1 byte", attr_offset[15:8], 4);
      chk(attr_offset[23:16] == 8'd8, "R2 byte after pad", attr_offset[23:16], 8);
      chk(attr_offset[31:24] == 8'd12, "R2 short after 3 bytes", attr_offset[31:24], 12);
      cfg_type = 48'h18D4; cfg_cnt = 24'h04; cfg_stride = 8'd17;
      #1;
      chk(attr_offset[15:8] == 8'd4, "R3 pad after short", attr_offset[15:8], 4);
      chk(attr_offset[23:16] == 8'd12, "R1 float after 8-byte pad", attr_offset[23:16], 12);
      chk(attr_offset[31:24] == 8'd16, "R2 byte after float", attr_offset[31:24], 16);
      chk(cfg_err == 1'b0, "R4 unrounded 17", cfg_err, 0);

      // Stride rounded up to 4 is an error and blocks requests.
      cfg_stride = 8'd20;
      @(negedge clk);
      chk(cfg_err == 1'b1, "R4 rounded stride", cfg_err, 1);
      vtx_valid = 1'b1; vtx_index = 16'd3;
      @(negedge clk);
      chk(vtx_ready == 1'b0, "R5 ready low", vtx_ready, 0);
      repeat (2) @(negedge clk);
      chk(out_valid == 1'b0, "R5 no emission", out_valid, 0);
      cfg_stride = 8'd18;
      @(negedge clk);
      chk(cfg_err && !out_valid, "R5 stride+1", {cfg_err, out_valid}, 2);
      vtx_valid = 1'b0;

      // Count out of range.
      cfg_stride = 8'd17; cfg_num_attr = 4'd0;
      #1 chk(cfg_err == 1'b1, "R4 zero count", cfg_err, 1);
      cfg_num_attr = 4'd13;
      #1 chk(cfg_err == 1'b1, "R4 count 13", cfg_err, 1);
      cfg_num_attr = 4'd4;
      #1 chk(cfg_err == 1'b0, "R4 restored", cfg_err, 0);

      // Back-pressure on the first beat.
      @(negedge clk);
      vtx_index = 16'd2; vtx_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      vtx_valid = 1'b0; out_ready = 1'b0;
      for (int s = 0; s < 3; s++) begin
         @(negedge clk);
         chk(out_valid && out_attr == 4'd0 && out_addr == 32'h1000_0022,
             "R7 stall hold", out_addr, 32'h1000_0022);
      end
      out_ready = 1'b1;
      @(negedge clk);
      chk(out_attr == 4'd1 && out_addr == 32'h1000_0026, "R7 resume", out_addr, 32'h1000_0026);
      repeat (3) @(negedge clk);
      chk(!out_valid && vtx_ready, "R8 back to idle", {out_valid, vtx_ready}, 1);

      // Largest index.
      run_vertex(65535, 4, "max index");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

endmodule